// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers a parameterized number of external interrupt lines and turns them into a single prioritized request for a processor. Every line passes through a two-stage synchronizer. Each line then has its own configuration word. That word holds a block bit, a choice between level and edge sensing, a polarity bit and a priority level. All configuration is written through a simple write port. An optional priority threshold can block every line whose level is at or below a programmed value.

The processor sees the request, the number of the winning line and the priority of that line. All three come from registers. When the processor accepts a request it pulses `take`, and that line is then in service. An in-service line is not offered again until the processor acknowledges it by number. Once it is acknowledged it may be offered on the very next cycle. A global gate sits on the processor side, separate from the per-line block bits. Software can close it, open it unconditionally or load it with a saved value, and its current state can always be read back.

Top module: `irqc_top`

## Requirements
- R1: After reset, `irq_req` is 0 and `gate_state` is 0. Every line starts blocked and level-sensed, active high, at priority 0, with the threshold off. While every line is still blocked, active inputs raise no request, even with the gate open.
- R2: A line whose block bit is 1 is never offered. An edge captured while the line is blocked stays pending, and the line is offered once its block bit is cleared.
- R3: A level-sensed line (edge bit 0) is active while its synchronized input equals its polarity bit (1 = high, 0 = low). A change on the input shows at `irq_req` within 4 clocks.
- R4: An edge-sensed line (edge bit 1) latches a pending flag on a rising edge when polarity is 1 and on a falling edge when polarity is 0. The opposite edge is ignored. The pending flag stays set after the input returns to idle.
- R5: Among the eligible lines, the one with the highest priority is offered, and a tie goes to the lowest line number. `irq_vec` is 0 whenever `irq_req` is 0.
- R6: A `take` pulse while `irq_req` is 1 puts the offered line in service. From the next cycle on, that line is not offered until it is acknowledged, even if its level input stays active.
- R7: An acknowledge (`ack_valid` with line number `ack_vec`) clears the in-service state and the edge pending flag of that line. The next eligible line, which may be the same line if it is still active, is offered from the following cycle.
- R8: If an edge arrives in the same cycle as the acknowledge of its own line, the new edge wins and the line stays pending.
- R9: While the threshold is enabled, any line whose priority is at or below the threshold level is not offered.
- R10: `gate_cmd` controls the global gate: 2'b01 closes it, 2'b10 opens it, 2'b11 loads `gate_restore` into it and 2'b00 holds it. `gate_state` shows the new state one cycle after the command. While the gate is closed, `irq_req` is 0 and pending state is kept.
- R11: A write to address v (v < N_VEC) loads line v's configuration: bit 0 block, bit 1 edge, bit 2 polarity, bits [3 +: PRIO_W] priority. A write to address N_VEC loads the threshold: bits [PRIO_W-1:0] level, bit PRIO_W enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_VEC | Asynchronous interrupt lines |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Line number, or N_VEC for the threshold |
| wr_data | input | DATA_W | Configuration word |
| take | input | 1 | Processor accepts the offered line |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vec | input | VEC_W | Line being acknowledged |
| gate_cmd | input | 2 | Global gate command |
| gate_restore | input | 1 | Value loaded by the restore command |
| gate_state | output | 1 | Current global gate state |
| irq_req | output | 1 | Registered request to the processor |
| irq_vec | output | VEC_W | Offered line number |
| irq_prio | output | PRIO_W | Priority of the offered line |

## Verification
Two events can land in the same cycle for one edge-sensed line: a new edge reaching the pending flag, and the acknowledge that clears that flag. The bench first has the line taken. It then raises the input again and times the acknowledge so that it hits the clock edge where the synchronized edge is detected. After the input has settled, the line must be offered again. If the acknowledge had won, the request would stay low. The take-then-acknowledge flow on lines with different priorities also shows that an acknowledge lets the next candidate through at once.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // field positions inside a per-line configuration word
  localparam int CFG_BLOCK = 0;
  localparam int CFG_EDGE  = 1;
  localparam int CFG_POL   = 2;
  localparam int CFG_PRIO  = 3;

  typedef enum logic [1:0] {
    GATE_HOLD = 2'b00,
    GATE_OFF  = 2'b01,
    GATE_ON   = 2'b10,
    GATE_LOAD = 2'b11
  } gate_cmd_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] lvl_prev
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic meta, stab, hist;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= 1'b0;
        stab <= 1'b0;
        hist <= 1'b0;
      end else begin
        meta <= raw[g];
        stab <= meta;
        hist <= stab;
      end
    end
    assign lvl[g]      = stab;
    assign lvl_prev[g] = hist;
  end
endmodule

// File: rtl/irqc_vec.sv
module irqc_vec
  import irqc_pkg::*;
#(
  parameter int PRIO_W = 3,
  localparam int DATA_W = PRIO_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              lvl,
  input  logic              lvl_prev,
  input  logic              take_hit,
  input  logic              ack_hit,
  input  logic              thr_en,
  input  logic [PRIO_W-1:0] thr_lvl,
  output logic              elig,
  output logic [PRIO_W-1:0] prio
);
  logic              blk_q, edge_q, pol_q;
  logic [PRIO_W-1:0] prio_q;
  logic              pend_q, pend_d;
  logic              ins_q, ins_d;
  logic              det, active, thr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q  <= 1'b1;
      edge_q <= 1'b0;
      pol_q  <= 1'b1;
      prio_q <= '0;
    end else if (cfg_we) begin
      blk_q  <= cfg_wdata[CFG_BLOCK];
      edge_q <= cfg_wdata[CFG_EDGE];
      pol_q  <= cfg_wdata[CFG_POL];
      prio_q <= cfg_wdata[CFG_PRIO +: PRIO_W];
    end
  end

  // edge seen on the synchronized line in the selected direction
  assign det = pol_q ? (lvl & ~lvl_prev) : (~lvl & lvl_prev);

  // a fresh edge outranks a simultaneous acknowledge
  assign pend_d = edge_q & ((pend_q & ~ack_hit) | det);
  // a fresh take outranks a simultaneous acknowledge
  assign ins_d  = (ins_q & ~ack_hit) | take_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ins_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ins_q  <= ins_d;
    end
  end

  assign active = edge_q ? pend_d : (lvl == pol_q);
  assign thr_ok = ~thr_en | (prio_q > thr_lvl);
  assign elig   = active & ~ins_d & ~blk_q & thr_ok;
  assign prio   = prio_q;
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int N_VEC  = 8,
  parameter int PRIO_W = 3,
  localparam int VEC_W = $clog2(N_VEC)
) (
  input  logic [N_VEC-1:0]             elig,
  input  logic [N_VEC-1:0][PRIO_W-1:0] prio,
  output logic                         found,
  output logic [VEC_W-1:0]             win_idx,
  output logic [PRIO_W-1:0]            win_prio
);
  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = N_VEC - 1; i >= 0; i--) begin
      if (elig[i] && (!found || prio[i] >= win_prio)) begin
        found    = 1'b1;
        win_idx  = VEC_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_VEC  = 8,
  parameter int PRIO_W = 3,
  localparam int VEC_W  = $clog2(N_VEC),
  localparam int ADDR_W = $clog2(N_VEC + 1),
  localparam int DATA_W = PRIO_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_VEC-1:0]  irq_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  input  logic              ack_valid,
  input  logic [VEC_W-1:0]  ack_vec,
  input  logic [1:0]        gate_cmd,
  input  logic              gate_restore,
  output logic              gate_state,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [PRIO_W-1:0] irq_prio
);
  logic [N_VEC-1:0]             lvl, lvl_prev, elig;
  logic [N_VEC-1:0][PRIO_W-1:0] prio;
  logic                         found;
  logic [VEC_W-1:0]             win_idx;
  logic [PRIO_W-1:0]            win_prio;
  logic                         thr_en_q;
  logic [PRIO_W-1:0]            thr_lvl_q;
  logic                         gate_q, gate_d;
  logic                         req_q;
  logic [VEC_W-1:0]             vec_q;
  logic [PRIO_W-1:0]            prio_q;

  irqc_sync #(.LINES(N_VEC)) u_sync (
    .clk(clk), .rst(rst), .raw(irq_in), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  for (genvar v = 0; v < N_VEC; v++) begin : g_vec
    logic we, th, ah;
    assign we = wr_en && (wr_addr == ADDR_W'(v));
    assign th = take && req_q && (vec_q == VEC_W'(v));
    assign ah = ack_valid && (ack_vec == VEC_W'(v));
    irqc_vec #(.PRIO_W(PRIO_W)) u_vec (
      .clk(clk), .rst(rst), .cfg_we(we), .cfg_wdata(wr_data),
      .lvl(lvl[v]), .lvl_prev(lvl_prev[v]), .take_hit(th), .ack_hit(ah),
      .thr_en(thr_en_q), .thr_lvl(thr_lvl_q),
      .elig(elig[v]), .prio(prio[v])
    );
  end

  irqc_arb #(.N_VEC(N_VEC), .PRIO_W(PRIO_W)) u_arb (
    .elig(elig), .prio(prio), .found(found),
    .win_idx(win_idx), .win_prio(win_prio)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_en_q  <= 1'b0;
      thr_lvl_q <= '0;
    end else if (wr_en && wr_addr == ADDR_W'(N_VEC)) begin
      thr_en_q  <= wr_data[PRIO_W];
      thr_lvl_q <= wr_data[PRIO_W-1:0];
    end
  end

  always_comb begin
    case (gate_cmd_e'(gate_cmd))
      GATE_OFF:  gate_d = 1'b0;
      GATE_ON:   gate_d = 1'b1;
      GATE_LOAD: gate_d = gate_restore;
      default:   gate_d = gate_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      req_q  <= 1'b0;
      vec_q  <= '0;
      prio_q <= '0;
    end else begin
      gate_q <= gate_d;
      req_q  <= found && gate_d;
      vec_q  <= (found && gate_d) ? win_idx : '0;
      prio_q <= (found && gate_d) ? win_prio : '0;
    end
  end

  assign gate_state = gate_q;
  assign irq_req    = req_q;
  assign irq_vec    = vec_q;
  assign irq_prio   = prio_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N_VEC = 8,
  localparam int VEC_W = $clog2(N_VEC)
) (
  input logic             clk,
  input logic             rst,
  input logic             take,
  input logic [1:0]       gate_cmd,
  input logic             gate_restore,
  input logic             gate_state,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec
);
  // R6: a taken line is not offered on the following cycle
  a_r6_no_redelivery: assert property (@(posedge clk) disable iff (rst)
    (take && irq_req) |=> !(irq_req && irq_vec == $past(irq_vec)));

  // R10: no request while the gate is closed
  a_r10_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> gate_state);

  a_r10_close: assert property (@(posedge clk) disable iff (rst)
    (gate_cmd == 2'b01) |=> !gate_state);

  a_r10_open: assert property (@(posedge clk) disable iff (rst)
    (gate_cmd == 2'b10) |=> gate_state);

  a_r10_load: assert property (@(posedge clk) disable iff (rst)
    (gate_cmd == 2'b11) |=> (gate_state == $past(gate_restore)));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (gate_cmd == 2'b00) |=> $stable(gate_state));
endmodule

bind irqc_top irqc_chk #(.N_VEC(N_VEC)) u_chk (
  .clk(clk), .rst(rst), .take(take), .gate_cmd(gate_cmd),
  .gate_restore(gate_restore), .gate_state(gate_state),
  .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
  localparam int N_VEC  = 8;
  localparam int PRIO_W = 3;
  localparam int VEC_W  = 3;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N_VEC-1:0]  irq_in = '0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              take = 1'b0;
  logic              ack_valid = 1'b0;
  logic [VEC_W-1:0]  ack_vec = '0;
  logic [1:0]        gate_cmd = 2'b00;
  logic              gate_restore = 1'b0;
  logic              gate_state;
  logic              irq_req;
  logic [VEC_W-1:0]  irq_vec;
  logic [PRIO_W-1:0] irq_prio;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irqc_top #(.N_VEC(N_VEC), .PRIO_W(PRIO_W)) i_irqc_top (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .take(take), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .gate_cmd(gate_cmd), .gate_restore(gate_restore), .gate_state(gate_state),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_prio(irq_prio)
  );

  // line priorities used by the vector table
  localparam int PR [N_VEC] = '{1, 3, 3, 5, 2, 7, 5, 0};
  // {irq_in[7:0], exp_req, 4'b0, exp_vec[2:0]}
  localparam logic [15:0] TBL [12] = '{
    16'h0000, 16'h0180, 16'h0381, 16'h0681, 16'h0482, 16'h4883,
    16'h4086, 16'h7F85, 16'h8087, 16'h9084, 16'h0C83, 16'hFF85
  };

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic er, input int ev);
    checks++;
    if (irq_req !== er || (er && irq_vec !== VEC_W'(ev)) || (!er && irq_vec !== '0)) begin
      errors++;
      $display("FAIL %s: req=%0b vec=%0d expected req=%0b vec=%0d",
               tag, irq_req, irq_vec, er, er ? ev : 0);
    end
  endtask

  task automatic chk_gate(input string tag, input logic eg);
    checks++;
    if (gate_state !== eg) begin
      errors++;
      $display("FAIL %s: gate_state=%0b expected %0b", tag, gate_state, eg);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic gate(input logic [1:0] c, input logic v);
    @(negedge clk);
    gate_cmd = c; gate_restore = v;
    @(negedge clk);
    gate_cmd = 2'b00;
  endtask

  task automatic do_take();
    @(negedge clk) take = 1'b1;
    @(negedge clk) take = 1'b0;
  endtask

  task automatic do_ack(input int v);
    @(negedge clk) begin ack_valid = 1'b1; ack_vec = VEC_W'(v); end
    @(negedge clk) ack_valid = 1'b0;
  endtask

  task automatic pulse(input int b);
    @(negedge clk) irq_in[b] = 1'b1;
    repeat (2) @(negedge clk);
    irq_in[b] = 1'b0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset request", 1'b0, 0);
    chk_gate("R1 reset gate", 1'b0);

    // R1: all lines start blocked
    irq_in = '1;
    gate(2'b10, 1'b0);
    settle();
    chk("R1 blocked after reset", 1'b0, 0);
    irq_in = '0;

    // R11: configure every line level, active high, unblocked
    for (int v = 0; v < N_VEC; v++) wr(v, (PR[v] << 3) | 4);
    settle();

    // R5 / R3: walk the table
    for (int k = 0; k < 12; k++) begin
      irq_in = TBL[k][15:8];
      settle();
      chk($sformatf("R5 table entry %0d", k), TBL[k][7], int'(TBL[k][2:0]));
    end

    // R10: global gate
    irq_in = 8'h01;
    settle();
    chk("R10 open gate", 1'b1, 0);
    gate(2'b01, 1'b0);
    chk_gate("R10 closed state", 1'b0);
    settle();
    chk("R10 closed blocks", 1'b0, 0);
    gate(2'b11, 1'b1);
    chk_gate("R10 load 1", 1'b1);
    settle();
    chk("R10 load 1 request", 1'b1, 0);
    gate(2'b11, 1'b0);
    chk_gate("R10 load 0", 1'b0);
    gate(2'b10, 1'b0);
    chk_gate("R10 reopen", 1'b1);
    settle();
    chk("R10 reopen request", 1'b1, 0);

    // R2: block bit
    wr(0, (1 << 3) | 4 | 1);
    settle();
    chk("R2 blocked level line", 1'b0, 0);
    wr(0, (1 << 3) | 4);
    settle();
    chk("R2 unblocked level line", 1'b1, 0);

    // R3: active-low level line
    wr(0, (1 << 3));
    settle();
    chk("R3 active low, input high", 1'b0, 0);
    irq_in = 8'h00;
    settle();
    chk("R3 active low, input low", 1'b1, 0);
    wr(0, 1);
    settle();
    chk("R2 line 0 blocked again", 1'b0, 0);

    // R4: rising edge on line 1
    wr(1, (3 << 3) | 4 | 2);
    pulse(1);
    chk("R4 rising edge latched", 1'b1, 1);
    do_take();
    settle();
    chk("R6 taken edge line not offered", 1'b0, 0);
    do_ack(1);
    settle();
    chk("R7 ack clears pending", 1'b0, 0);

    // R8: new edge in the same cycle as the acknowledge
    pulse(1);
    chk("R8 first delivery", 1'b1, 1);
    do_take();
    settle();
    @(negedge clk) irq_in[1] = 1'b1;
    repeat (2) @(negedge clk);
    ack_valid = 1'b1; ack_vec = 3'd1;
    @(negedge clk) ack_valid = 1'b0;
    irq_in[1] = 1'b0;
    settle();
    chk("R8 edge beats ack", 1'b1, 1);
    do_take();
    do_ack(1);
    settle();
    chk("R8 cleanup", 1'b0, 0);

    // R4: falling edge on line 2, rising ignored
    wr(2, (3 << 3) | 2);
    settle();
    irq_in[2] = 1'b1;
    settle();
    chk("R4 rising ignored on falling line", 1'b0, 0);
    irq_in[2] = 1'b0;
    settle();
    chk("R4 falling edge latched", 1'b1, 2);
    do_take();
    do_ack(2);
    settle();
    chk("R7 falling line released", 1'b0, 0);

    // R6 / R7: level lines 5 (prio 7) and 3 (prio 5)
    irq_in = 8'h28;
    settle();
    chk("R5 higher level line first", 1'b1, 5);
    do_take();
    chk("R7 next candidate after take", 1'b1, 3);
    do_take();
    settle();
    chk("R6 both in service", 1'b0, 0);
    do_ack(5);
    chk("R7 acked line offered at once", 1'b1, 5);
    do_take();
    do_ack(3);
    do_ack(5);
    irq_in = 8'h00;
    settle();
    chk("R7 all released", 1'b0, 0);

    // R2: edge captured while blocked
    wr(1, (3 << 3) | 4 | 2 | 1);
    pulse(1);
    chk("R2 blocked edge line", 1'b0, 0);
    wr(1, (3 << 3) | 4 | 2);
    settle();
    chk("R2 pending edge after unblock", 1'b1, 1);
    do_take();
    do_ack(1);

    // R9: threshold
    irq_in = 8'h10;
    wr(N_VEC, 8 | 2);
    settle();
    chk("R9 priority equal to threshold", 1'b0, 0);
    wr(N_VEC, 8 | 1);
    settle();
    chk("R9 priority above threshold", 1'b1, 4);
    wr(N_VEC, 8 | 7);
    settle();
    chk("R9 high threshold", 1'b0, 0);
    wr(N_VEC, 0);
    settle();
    chk("R9 threshold off", 1'b1, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule